// File: doc/BRIEF.md
# Scanned Six-Digit BCD Display Driver with Hold Latch

This block takes a six-digit packed BCD value and presents it on a time-multiplexed display, one digit at a time. Each digit is shown in two forms at once: a seven-segment pattern and its 4-bit BCD code. A hold stage sits between the live value and the display. While the transfer control is high, the display follows the live value in the same cycle. While it is low, the display keeps the value it last captured, even if the live value keeps changing.

A one-hot ring moves the active digit from the least significant position toward the most significant. It advances one position on each scan-step pulse and wraps back to the least significant digit. Zeros to the left of the first nonzero digit are blanked, so their segments are off. The least significant digit is never blanked. A blanking-override input turns off all blanking, for example so that zeros next to a decimal point stay visible.

Top module: `bcd_scan_display`

## Requirements
- R1: While `xfer_en` is high, the selected digit's `seg` and `bcd_out` come from the live `count_bcd` in the same cycle, and the hold stage captures that value at the clock edge.
- R2: While `xfer_en` is low, the hold stage keeps its contents across clock edges, and `seg` and `bcd_out` come from the held value whatever `count_bcd` does.
- R3: During and right after reset, the held value is all zeros and only the least significant digit select (`digit_sel[0]`) is active.
- R4: Exactly one bit of `digit_sel` is high at all times. A clock edge with `scan_step` high moves the active bit from index i to i+1, and index 5 (most significant) wraps to index 0. With `scan_step` low the select does not change.
- R5: `bcd_out` equals the 4-bit code of the selected digit. Digit i occupies bits [4i+3:4i] of `count_bcd`. Blanking never affects `bcd_out`.
- R6: `seg` is active high with bit 0 = a, 1 = b, 2 = c, 3 = d, 4 = e, 5 = f and 6 = g. Codes 0 to 9 light the standard segment sets. Codes 10 to 15 light no segment.
- R7: With `blank_ovr` low, a selected digit at index 1 or above is blanked (`seg` = 0) when it and every digit above it are zero. The digit at index 0 is never blanked.
- R8: With `blank_ovr` high, no digit is blanked, and a zero digit shows the pattern for 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_bcd | input | 24 | Live six-digit packed BCD value, digit 0 in the low nibble |
| xfer_en | input | 1 | High: display follows the live value; low: display holds |
| scan_step | input | 1 | Advances the scanned digit by one at the clock edge |
| blank_ovr | input | 1 | High disables leading-zero blanking |
| digit_sel | output | 6 | One-hot digit select, bit 0 = least significant |
| seg | output | 7 | Segment outputs a (bit 0) through g (bit 6), active high |
| bcd_out | output | 4 | BCD code of the selected digit |

## Verification
The bench targets these corner cases:

- **All-zero value.** Only the least significant digit should show a 0. A design that blanks every zero would leave the display dark.
- **Interior zeros.** Patterns like 000100 must keep the zeros below the first nonzero digit visible. A design that blanks every zero digit would drop them.
- **Hold during live changes.** The bench changes the live value while the hold is active. A design that captures the value too early or too late shows digits that do not match the reference.
- **Scan wrap.** The bench checks the step from the most significant digit back to the least significant. A design that gets this wrong ends up with an empty select or a stuck select.
- **Invalid codes and override.** Codes 10 to 15 must produce dark segments while their BCD code still appears on `bcd_out`. The override input must bring back displayed zeros.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;

  // Active-high segments, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] seg_decode(input logic [NIB_W-1:0] code);
    logic [SEG_W-1:0] s;
    case (code)
      4'd0: s = 7'b0111111;
      4'd1: s = 7'b0000110;
      4'd2: s = 7'b1011011;
      4'd3: s = 7'b1001111;
      4'd4: s = 7'b1100110;
      4'd5: s = 7'b1101101;
      4'd6: s = 7'b1111101;
      4'd7: s = 7'b0000111;
      4'd8: s = 7'b1111111;
      4'd9: s = 7'b1101111;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bsd_hold.sv
module bsd_hold #(
  parameter int DIGITS = 6,
  localparam int W = DIGITS * bsd_pkg::NIB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic         xfer_en,
  output logic [W-1:0] shown
);
  logic [W-1:0] held_q;

  assign shown = xfer_en ? live : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= shown;
  end

  // R2
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> $stable(held_q));
  // R1
  hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |=> held_q == $past(live));
endmodule

// File: rtl/bsd_scan.sv
module bsd_scan #(
  parameter int DIGITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [DIGITS-1:0] sel
);
  logic [DIGITS-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= DIGITS'(1);
    else if (step) sel_q <= {sel_q[DIGITS-2:0], sel_q[DIGITS-1]};
  end

  assign sel = sel_q;

  // R4
  scan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_q) == 1);
  // R4
  scan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sel_q));
  // R4
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sel_q[DIGITS-1]) |=> sel_q[0]);
endmodule

// File: rtl/bsd_blank.sv
module bsd_blank #(
  parameter int DIGITS = 6,
  localparam int W = DIGITS * bsd_pkg::NIB_W
) (
  input  logic [W-1:0]      digits,
  input  logic              ovr,
  output logic [DIGITS-1:0] mask
);
  logic [DIGITS-1:0] is_zero;
  logic [DIGITS-1:0] lead_zero;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      assign is_zero[i] = (digits[i*bsd_pkg::NIB_W +: bsd_pkg::NIB_W] == '0);
      if (i == DIGITS - 1) begin : g_top
        assign lead_zero[i] = is_zero[i];
      end else begin : g_low
        assign lead_zero[i] = is_zero[i] & lead_zero[i+1];
      end
      if (i == 0) begin : g_lsd
        assign mask[i] = 1'b0;
      end else begin : g_up
        assign mask[i] = lead_zero[i] & ~ovr;
      end
    end
  endgenerate
endmodule

// File: rtl/bcd_scan_display.sv
module bcd_scan_display #(
  parameter int DIGITS = 6,
  localparam int W = DIGITS * bsd_pkg::NIB_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W-1:0]          count_bcd,
  input  logic                  xfer_en,
  input  logic                  scan_step,
  input  logic                  blank_ovr,
  output logic [DIGITS-1:0]     digit_sel,
  output logic [6:0]            seg,
  output logic [3:0]            bcd_out
);
  logic [W-1:0]      shown;
  logic [DIGITS-1:0] blank_mask;
  logic [3:0]        cur_code;
  logic              cur_blank;

  bsd_hold #(.DIGITS(DIGITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .live(count_bcd), .xfer_en(xfer_en), .shown(shown));

  bsd_scan #(.DIGITS(DIGITS)) u_scan (
    .clk(clk), .rst_n(rst_n), .step(scan_step), .sel(digit_sel));

  bsd_blank #(.DIGITS(DIGITS)) u_blank (
    .digits(shown), .ovr(blank_ovr), .mask(blank_mask));

  always_comb begin
    cur_code  = '0;
    cur_blank = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      if (digit_sel[i]) begin
        cur_code  = cur_code | shown[i*4 +: 4];
        cur_blank = cur_blank | blank_mask[i];
      end
    end
  end

  assign bcd_out = cur_code;
  assign seg     = cur_blank ? 7'd0 : bsd_pkg::seg_decode(cur_code);

  // R7
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_blank |-> seg == 7'd0);
  // R7
  lsd_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digit_sel[0] |-> !cur_blank);
  // R8
  ovr_noblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_ovr |-> !cur_blank);
endmodule

// File: tb/sim_bcd_scan_display.sv
`timescale 1ns/1ps
module sim_bcd_scan_display;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] count_bcd = '0;
  logic        xfer_en = 1'b0, scan_step = 1'b0, blank_ovr = 1'b0;
  logic [5:0]  digit_sel;
  logic [6:0]  seg;
  logic [3:0]  bcd_out;

  int tests = 0, fails = 0;
  bit done = 0;
  int held[6];
  int idx;

  always #2 clk = ~clk;

  bcd_scan_display u0 (.clk(clk), .rst_n(rst_n), .count_bcd(count_bcd),
    .xfer_en(xfer_en), .scan_step(scan_step), .blank_ovr(blank_ovr),
    .digit_sel(digit_sel), .seg(seg), .bcd_out(bcd_out));

  function automatic logic [6:0] ref_seg(input int d);
    string s;
    logic [6:0] r = '0;
    case (d)
      0: s = "abcdef";  1: s = "bc";     2: s = "abdeg";  3: s = "abcdg";
      4: s = "bcfg";    5: s = "acdfg";  6: s = "acdefg"; 7: s = "abc";
      8: s = "abcdefg"; 9: s = "abcdfg"; default: s = "";
    endcase
    for (int k = 0; k < s.len(); k++) r[s[k] - "a"] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_now(input bit xf, input logic [23:0] live, input bit ovr);
    int vis[6];
    bit lit;
    int exp_seg;
    for (int i = 0; i < 6; i++) vis[i] = xf ? int'(live[i*4 +: 4]) : held[i];
    check("R4 select", int'(digit_sel), 1 << idx);
    check("R5 bcd", int'(bcd_out), vis[idx]);
    lit = ovr || idx == 0;
    for (int i = idx; i < 6; i++) if (vis[i] != 0) lit = 1;
    exp_seg = lit ? int'(ref_seg(vis[idx])) : 0;
    check(ovr ? "R8 seg" : (lit ? "R6/R1/R2 seg" : "R7 seg"), int'(seg), exp_seg);
  endtask

  task automatic cyc(input logic [23:0] live, input bit xf, input bit st, input bit ovr);
    @(negedge clk);
    count_bcd = live; xfer_en = xf; scan_step = st; blank_ovr = ovr;
    #1;
    compare_now(xf, live, ovr);
    @(posedge clk);
    if (xf) for (int i = 0; i < 6; i++) held[i] = int'(live[i*4 +: 4]);
    if (st) idx = (idx + 1) % 6;
  endtask

  function automatic logic [23:0] rnd_val(input int zeros_top);
    logic [23:0] v = '0;
    for (int i = 0; i < 6; i++) begin
      int d = ($urandom_range(0, 9) == 0) ? int'($urandom_range(10, 15)) : int'($urandom_range(0, 9));
      if (i >= 6 - zeros_top) d = 0;
      v[i*4 +: 4] = 4'(d);
    end
    return v;
  endfunction

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) held[i] = 0;
    idx = 0;
    // R3: during reset, live value changes but hold is off
    repeat (2) begin
      @(negedge clk); count_bcd = 24'h987654; #1;
      compare_now(0, count_bcd, 0);
      check("R3 reset sel", int'(digit_sel), 1);
    end
    @(negedge clk); rst_n = 1'b1;
    // R7: all zero, full scan with wrap (R4)
    for (int k = 0; k < 8; k++) cyc(24'h000000, 1, 1, 0);
    // R7: interior zeros
    for (int k = 0; k < 7; k++) cyc(24'h000100, 1, 1, 0);
    // R8 override
    for (int k = 0; k < 7; k++) cyc(24'h000100, 1, 1, 1);
    // R2 hold: live changes, xfer low
    for (int k = 0; k < 12; k++) cyc(rnd_val(0), 0, 1, 0);
    // R4 idle: no step
    for (int k = 0; k < 4; k++) cyc(24'h120000, 1, 0, 0);
    // R6 invalid codes
    for (int k = 0; k < 7; k++) cyc(24'h0fedcb, 1, 1, 0);
    // mixed random
    for (int k = 0; k < 300; k++)
      cyc(rnd_val(int'($urandom_range(0, 6))), bit'($urandom_range(0, 1)),
          bit'($urandom_range(0, 1)), ($urandom_range(0, 4) == 0));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule